// File: doc/BRIEF.md
# Binned Hit Chain Store

This block collects the detector hits of one event and hands them back grouped by coarse bin. During the write phase each hit arrives with a coarse bin number and a full-resolution hit word. The word goes into a hit memory at the next free address, in arrival order, and is never sorted. A link memory, indexed by hit address, threads together all hits of the same bin. A head table keeps the address of the most recent hit of each bin. A per-bin valid vector records which bins received data in the current event.

During the read phase a consumer presents a bin number, typically one per layer of a matched road. The block then walks that bin's chain one hit per clock, from the newest hit to the oldest, and flags the final beat. A bin with no hits answers at once with a single empty-marker beat. The valid vector is also exposed eight adjacent bins at a time, so a whole group can be tested for data in one look. An event-clear pulse empties every bin in one cycle and rewinds the write address.

Top module: `hit_chain_store`

## Requirements
- R1: After reset, `wr_ready` is 1, `q_ready` is 1, `out_valid` is 0 and `grp_occ` is 0 for every group.
- R2: A hit is stored on each clock where `wr_valid` and `wr_ready` are both 1, so one hit can be stored per cycle. `wr_ready` is 0 once MAX_HITS hits are stored in the event. A write offered while `wr_ready` is 0 is dropped and changes no bin's contents.
- R3: A query accepted on a clock edge (`q_valid` and `q_ready` both 1) for a bin holding N≥1 hits produces N consecutive `out_valid` beats, starting in the cycle after that edge. The beats carry that bin's hit words from the most recently written to the earliest, with `out_empty` at 0.
- R4: On a non-empty stream, `out_last` is 1 on the final beat only.
- R5: A query for a bin with no hits in the current event produces exactly one beat, in the cycle after acceptance, with `out_empty`=1, `out_last`=1 and `out_hit`=0.
- R6: Bit i of `grp_occ` is 1 exactly when bin `grp_sel`*8+i holds at least one hit in the current event.
- R7: `q_ready` is 0 while an output beat is being presented, so queries are not accepted during a stream.
- R8: An `evt_clr` pulse discards every stored hit in one cycle. In the following cycle all `grp_occ` bits are 0, `wr_ready` is 1, any stream in progress is cut off, and every bin then answers a query as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_clr | input | 1 | Start of a new event, empties all bins |
| wr_valid | input | 1 | Hit offered for storage |
| wr_ready | output | 1 | Store has room for another hit |
| wr_bin | input | BIN_W | Coarse bin of the offered hit |
| wr_hit | input | HIT_W | Full-resolution hit word |
| q_valid | input | 1 | Bin query offered |
| q_ready | output | 1 | No stream in progress, query can be taken |
| q_bin | input | BIN_W | Bin to read out |
| out_valid | output | 1 | Output beat present |
| out_hit | output | HIT_W | Hit word of the beat |
| out_last | output | 1 | Final beat of the answer |
| out_empty | output | 1 | Beat is the empty marker |
| grp_sel | input | BIN_W-3 | Group of eight bins to inspect |
| grp_occ | output | 8 | Data present per bin of the selected group |

## Verification
The assertions take for granted that the read phase and the write phase do not overlap, so a chain is never extended while it is being walked, and that `q_valid` is only raised while the stream port is idle. The stimulus keeps to this. It writes a whole event, with random bins drawn from a narrow range so that long chains and empty bins both occur, then idles before querying every bin one by one and waiting for each answer to finish. Event-clear is pulsed only between phases, except for one directed pulse in the middle of a stream to cover the cut-off.

// File: rtl/hit_chain_store.sv
module hit_chain_store #(
  parameter int MAX_HITS = 256,
  parameter int BIN_W    = 6,
  parameter int HIT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_clr,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BIN_W-1:0] wr_bin,
  input  logic [HIT_W-1:0] wr_hit,
  input  logic             q_valid,
  output logic             q_ready,
  input  logic [BIN_W-1:0] q_bin,
  output logic             out_valid,
  output logic [HIT_W-1:0] out_hit,
  output logic             out_last,
  output logic             out_empty,
  input  logic [BIN_W-4:0] grp_sel,
  output logic [7:0]       grp_occ
);
  localparam int AW    = $clog2(MAX_HITS);
  localparam int NBINS = 1 << BIN_W;

  logic [HIT_W-1:0] hit_mem  [MAX_HITS];
  logic [AW:0]      link_mem [MAX_HITS];
  logic [AW-1:0]    head_tab [NBINS];
  logic [NBINS-1:0] bin_vld;
  logic [AW:0]      wr_cnt;
  logic [AW-1:0]    cur;
  logic             busy, empty_beat;

  wire wr_go = wr_valid && wr_ready && !evt_clr;
  wire q_go  = q_valid && q_ready && !evt_clr;
  wire [AW:0] cur_link = link_mem[cur];

  assign wr_ready  = wr_cnt < (AW+1)'(MAX_HITS);
  assign q_ready   = !busy && !empty_beat;
  assign out_valid = busy || empty_beat;
  assign out_empty = empty_beat;
  assign out_hit   = busy ? hit_mem[cur] : '0;
  assign out_last  = busy ? !cur_link[AW] : empty_beat;
  assign grp_occ   = bin_vld[grp_sel*8 +: 8];

  always_ff @(posedge clk) begin
    if (wr_go) begin
      hit_mem[wr_cnt[AW-1:0]]  <= wr_hit;
      link_mem[wr_cnt[AW-1:0]] <= {bin_vld[wr_bin], head_tab[wr_bin]};
      head_tab[wr_bin]         <= wr_cnt[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_vld    <= '0;
      wr_cnt     <= '0;
      busy       <= 1'b0;
      empty_beat <= 1'b0;
      cur        <= '0;
    end else if (evt_clr) begin
      bin_vld    <= '0;
      wr_cnt     <= '0;
      busy       <= 1'b0;
      empty_beat <= 1'b0;
    end else begin
      if (wr_go) begin
        bin_vld[wr_bin] <= 1'b1;
        wr_cnt          <= wr_cnt + 1'b1;
      end
      empty_beat <= 1'b0;
      if (busy) begin
        if (cur_link[AW]) cur <= cur_link[AW-1:0];
        else busy <= 1'b0;
      end else if (q_go) begin
        if (bin_vld[q_bin]) begin
          busy <= 1'b1;
          cur  <= head_tab[q_bin];
        end else begin
          empty_beat <= 1'b1;
        end
      end
    end
  end

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (grp_occ == 8'h00) && wr_ready && !out_valid);  // R8
  AST_EMPTY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_empty) |-> (out_last && out_hit == '0));  // R5
  AST_QUERY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready && !evt_clr) |=> out_valid);  // R3
  AST_STREAM_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !evt_clr) |=> (out_valid && !out_empty));  // R4
  AST_BUSY_NOQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !q_ready);  // R7
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !evt_clr) |=> !wr_ready);  // R2
endmodule

// File: tb/sim_hit_chain_store.sv
module sim_hit_chain_store;
  localparam int MAX_HITS = 256;
  localparam int BIN_W    = 6;
  localparam int HIT_W    = 16;
  localparam int NBINS    = 1 << BIN_W;

  logic clk = 0, rst_n = 0, evt_clr = 0;
  logic wr_valid = 0, q_valid = 0;
  logic [BIN_W-1:0] wr_bin = '0, q_bin = '0;
  logic [HIT_W-1:0] wr_hit = '0;
  logic [BIN_W-4:0] grp_sel = '0;
  logic wr_ready, q_ready, out_valid, out_last, out_empty;
  logic [HIT_W-1:0] out_hit;
  logic [7:0] grp_occ;

  int checks = 0, errors = 0;
  int m_cnt = 0;
  int m_bin [MAX_HITS];
  logic [HIT_W-1:0] m_hit [MAX_HITS];

  always #10 clk = ~clk;

  hit_chain_store #(.MAX_HITS(MAX_HITS), .BIN_W(BIN_W), .HIT_W(HIT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_clr(evt_clr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bin(wr_bin), .wr_hit(wr_hit),
    .q_valid(q_valid), .q_ready(q_ready), .q_bin(q_bin),
    .out_valid(out_valid), .out_hit(out_hit), .out_last(out_last), .out_empty(out_empty),
    .grp_sel(grp_sel), .grp_occ(grp_occ));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_occ(input int g);
    logic [7:0] r = '0;
    for (int i = 0; i < m_cnt; i++)
      if (m_bin[i] / 8 == g) r[m_bin[i] % 8] = 1'b1;
    return r;
  endfunction

  task automatic do_clear();
    @(negedge clk); evt_clr = 1;
    @(negedge clk); evt_clr = 0;
    m_cnt = 0;
  endtask

  task automatic wr(input int b, input logic [HIT_W-1:0] h);
    @(negedge clk);
    wr_valid = 1; wr_bin = BIN_W'(b); wr_hit = h;
    if (wr_ready) begin
      m_bin[m_cnt] = b; m_hit[m_cnt] = h; m_cnt++;
    end
  endtask

  task automatic wr_end();
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic query(input int b);
    int idx, n;
    @(negedge clk);
    chk("R7 q_ready idle", q_ready, 1);
    q_valid = 1; q_bin = BIN_W'(b);
    @(negedge clk); q_valid = 0;
    n = 0;
    for (int i = m_cnt - 1; i >= 0; i--) if (m_bin[i] == b) n++;
    if (n == 0) begin
      chk("R5 empty valid", out_valid, 1);
      chk("R5 empty flag", out_empty, 1);
      chk("R5 empty last", out_last, 1);
      chk("R5 empty hit", out_hit, 0);
      @(negedge clk);
      chk("R5 single beat", out_valid, 0);
    end else begin
      idx = m_cnt - 1;
      for (int k = 0; k < n; k++) begin
        while (m_bin[idx] != b) idx--;
        chk("R3 beat valid", out_valid, 1);
        chk("R3 hit order", out_hit, m_hit[idx]);
        chk("R3 not empty", out_empty, 0);
        chk("R4 last flag", out_last, (k == n - 1));
        chk("R7 busy", q_ready, 0);
        idx--;
        @(negedge clk);
      end
      chk("R3 stream end", out_valid, 0);
    end
  endtask

  task automatic check_groups();
    for (int g = 0; g < NBINS / 8; g++) begin
      @(negedge clk); grp_sel = (BIN_W-3)'(g);
      #1 chk("R6 group occupancy", grp_occ, exp_occ(g));
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 q_ready", q_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    rst_n = 1;
    check_groups();

    for (int i = 0; i < 120; i++) wr($urandom % 20, HIT_W'($urandom));
    wr(40, 16'hbeef);
    wr_end();
    check_groups();
    for (int b = 0; b < NBINS; b++) query(b);

    do_clear();
    chk("R8 wr_ready after clear", wr_ready, 1);
    check_groups();
    query(3);
    query(40);

    for (int i = 0; i < MAX_HITS; i++) wr(5, HIT_W'(i * 7 + 1));
    @(negedge clk);
    chk("R2 full wr_ready", wr_ready, 0);
    wr(9, 16'h1111);
    wr(5, 16'h2222);
    wr_end();
    chk("R2 full holds", wr_ready, 0);
    query(9);
    query(5);

    do_clear();
    for (int i = 0; i < 10; i++) wr(7, HIT_W'($urandom));
    wr_end();
    @(negedge clk); q_valid = 1; q_bin = 7;
    @(negedge clk); q_valid = 0;
    chk("R3 stream started", out_valid, 1);
    @(negedge clk); evt_clr = 1;
    @(negedge clk); evt_clr = 0; m_cnt = 0;
    chk("R8 stream cut", out_valid, 0);
    chk("R8 q_ready", q_ready, 1);
    query(7);

    for (int i = 0; i < 6; i++) wr(($urandom % 3) * 8 + 1, HIT_W'($urandom));
    wr_end();
    check_groups();
    for (int b = 0; b < 24; b++) query(b);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule